// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is a three-wire serial slave that holds seven 11-bit configuration registers for a clock generator. The host drives a serial clock, an active-low select and a data line. The block returns read data on a separate output with its own output enable, and the pad ring merges these into one bidirectional pin. The whole block runs on the serial clock itself and has an asynchronous active-low reset. Every register is exposed in parallel on a flat output bus, so the rest of the clock generator sees each field directly.

A frame is fifteen bits shifted in on rising clock edges while select is low: a direction flag, a 3-bit register number and eleven data bits, each field least significant bit first. The frame takes effect on the next rising edge seen while select is high. A write frame updates one register and leaves the rest alone. A read frame loads the chosen register back into the shift register and turns the data pin around. The host then lowers select again and clocks the register number and the register contents out, and the pin is released once select falls after that read-out.

The controller is a five-state machine. In `ST_IDLE` no frame is in progress. In `ST_RX` a frame is being shifted in. `ST_ARMED` means read data is loaded and the pin is being driven. In `ST_TX` read data is being shifted out, and `ST_TXEND` means the read-out is over but select is still high. The transitions are:
- idle-start: `ST_IDLE` to `ST_RX` on a select-low edge.
- write-commit: `ST_RX` to `ST_IDLE` on a select-high edge with flag 0.
- read-commit: `ST_RX` to `ST_ARMED` on a select-high edge with flag 1.
- tx-start: `ST_ARMED` to `ST_TX` on a select-low edge.
- tx-close: `ST_TX` to `ST_TXEND` on a select-high edge.
- turnaround: `ST_TXEND` to `ST_RX` on a select-low edge.
- Every other edge leaves the state as it is.

Top module: `ser_cfg_port`

## Requirements
- R1: While reset is low and after it is released, the registers hold their defaults: reg0=0x04F, reg1=0x003, reg2=0x006, reg3=0x013, reg4=0x5DC (gain field bits 2:0 = 4), reg5=0x5C1, reg6=0x047 (load-count field bits 2:0 = 7). In the same conditions the output enable is low. Register n occupies cfg_flat[11n+10:11n].
- R2: On each rising sclk edge with sel_n low, sdata_in is shifted in. A frame is the flag (1 = read, 0 = write), then address bits 0..2, then data bits 0..10. Only the last fifteen bits shifted before the commit edge count.
- R3: On a rising edge with sel_n high that follows a frame with flag 0, the data is written to the addressed register (0..6). All other registers keep their values, and sdata_in is ignored on that edge.
- R4: Rising edges with sel_n high that do not follow a received frame change no register.
- R5: A write to address 7 changes no register. A read of address 7 returns eleven zero data bits.
- R6: On the commit edge of a frame with flag 1, sdata_oe rises. sdata_out then shows address bit 0. Each following rising edge with sel_n low advances sdata_out through address bits 1 and 2 and then data bits 0 to 10.
- R7: sdata_oe stays high while sel_n is high after the read-out. It falls as soon as sel_n goes low again, and that low period starts a new frame.
- R8: An asynchronous reset in the middle of a frame discards the partial frame. A following select-high edge writes nothing.
- R9: A read leaves every register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Active-low frame select |
| sdata_in | input | 1 | Serial data from the host |
| sdata_out | output | 1 | Serial read data toward the pad |
| sdata_oe | output | 1 | Pad output enable for read data |
| cfg_flat | output | 77 | All seven registers, register n at bits 11n+10:11n |

## Verification
The bench aims at the read turnaround. It reads back each bit position with the data pin sampled between edges. A design that is off by one shift would return the address rotated into the data. A design that drops the enable too early would lose the last bits, and one that holds it too long would collide with the host's next frame. Writes and reads to address 7 check that the out-of-range slot neither takes the data nor aliases onto register 0. A frame with extra leading bits and a reset in the middle of a frame check that only the final fifteen bits count, and that a stale partial frame is never committed by the next select-high edge.

// File: rtl/ser_cfg_pkg.sv
package ser_cfg_pkg;

    parameter int DATA_W   = 11;
    parameter int ADDR_W   = 3;
    parameter int NUM_REGS = 7;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_RX    = 3'd1,
        ST_ARMED = 3'd2,
        ST_TX    = 3'd3,
        ST_TXEND = 3'd4
    } port_state_e;

    // Power-up contents of each configuration slot.
    function automatic logic [DATA_W-1:0] slot_default(input int idx);
        logic [DATA_W-1:0] v;
        case (idx)
            0:       v = 11'h04F;
            1:       v = 11'h003;
            2:       v = 11'h006;
            3:       v = 11'h013;
            4:       v = 11'h5DC;
            5:       v = 11'h5C1;
            6:       v = 11'h047;
            default: v = '0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/ser_cfg_shifter.sv
module ser_cfg_shifter #(
    parameter int DATA_W = 11,
    parameter int ADDR_W = 3,
    localparam int FRAME_W = 1 + ADDR_W + DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              din,
    input  logic              load_en,
    input  logic [DATA_W-1:0] load_data,
    output logic              frm_flag,
    output logic [ADDR_W-1:0] frm_addr,
    output logic [DATA_W-1:0] frm_data,
    output logic              dout
);

    logic [FRAME_W-1:0] sr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr <= '0;
        end else if (load_en) begin
            // bit 0 is a spare slot; bit 1 is driven first
            sr <= {load_data, sr[ADDR_W:1], 1'b0};
        end else if (shift_en) begin
            sr <= {din, sr[FRAME_W-1:1]};
        end
    end

    assign frm_flag = sr[0];
    assign frm_addr = sr[ADDR_W:1];
    assign frm_data = sr[FRAME_W-1:ADDR_W+1];
    assign dout     = sr[1];

    // R2: newest bit lands at the top of the frame
    a_r2_shift_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !load_en) |=> (sr[FRAME_W-1] == $past(din)));

endmodule

// File: rtl/ser_cfg_regfile.sv
module ser_cfg_regfile
    import ser_cfg_pkg::*;
#(
    parameter int DATA_W   = 11,
    parameter int ADDR_W   = 3,
    parameter int NUM_REGS = 7
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [DATA_W-1:0]          wr_data,
    output logic [DATA_W-1:0]          rd_data,
    output logic [NUM_REGS*DATA_W-1:0] regs_flat
);

    logic [NUM_REGS-1:0][DATA_W-1:0] slots;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                slots[i] <= slot_default(i);
            end
        end else if (wr_en) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                if (int'(addr) == i) begin
                    slots[i] <= wr_data;
                end
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (int'(addr) == i) begin
                rd_data = slots[i];
            end
        end
    end

    assign regs_flat = slots;

    // R5: out-of-range writes leave the whole file untouched
    a_r5_high_addr_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && int'(addr) >= NUM_REGS) |=> $stable(slots));

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_chk
        // R3: an addressed write lands in its slot
        a_r3_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && int'(addr) == g) |=> (slots[g] == $past(wr_data)));
    end

endmodule

// File: rtl/ser_cfg_ctrl.sv
module ser_cfg_ctrl
    import ser_cfg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sel_n,
    input  logic frm_flag,
    output logic shift_en,
    output logic wr_en,
    output logic load_en,
    output logic oe
);

    port_state_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (!sel_n) state_nx = ST_RX;
            ST_RX:    if (sel_n)  state_nx = frm_flag ? ST_ARMED : ST_IDLE;
            ST_ARMED: if (!sel_n) state_nx = ST_TX;
            ST_TX:    if (sel_n)  state_nx = ST_TXEND;
            ST_TXEND: if (!sel_n) state_nx = ST_RX;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        shift_en = !sel_n;
        wr_en    = 1'b0;
        load_en  = 1'b0;
        oe       = 1'b0;
        unique case (state)
            ST_IDLE:  ;
            ST_RX: begin
                wr_en   = sel_n && !frm_flag;
                load_en = sel_n && frm_flag;
            end
            ST_ARMED: oe = 1'b1;
            ST_TX:    oe = 1'b1;
            ST_TXEND: oe = sel_n;
            default:  ;
        endcase
    end

    // R6: a read commit turns the pin around on the next cycle
    a_r6_read_arms_oe: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> oe);

    // R7: enable is never dropped while select stays high
    a_r7_oe_holds_high_sel: assert property (@(posedge clk) disable iff (!rst_n)
        (oe && sel_n) |=> (oe || !sel_n));

    // R9: no write can commit while read data is on the pin
    a_r9_no_write_in_read: assert property (@(posedge clk) disable iff (!rst_n)
        oe |=> !wr_en || !$past(sel_n));

endmodule

// File: rtl/ser_cfg_port.sv
module ser_cfg_port
    import ser_cfg_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W,
    parameter int NR = NUM_REGS
) (
    input  logic             sclk,
    input  logic             rst_n,
    input  logic             sel_n,
    input  logic             sdata_in,
    output logic             sdata_out,
    output logic             sdata_oe,
    output logic [NR*DW-1:0] cfg_flat
);

    logic          shift_en;
    logic          wr_en;
    logic          load_en;
    logic          frm_flag;
    logic [AW-1:0] frm_addr;
    logic [DW-1:0] frm_data;
    logic [DW-1:0] rd_data;

    ser_cfg_ctrl u_ctrl (
        .clk      (sclk),
        .rst_n    (rst_n),
        .sel_n    (sel_n),
        .frm_flag (frm_flag),
        .shift_en (shift_en),
        .wr_en    (wr_en),
        .load_en  (load_en),
        .oe       (sdata_oe)
    );

    ser_cfg_shifter #(.DATA_W(DW), .ADDR_W(AW)) u_shift (
        .clk       (sclk),
        .rst_n     (rst_n),
        .shift_en  (shift_en),
        .din       (sdata_in),
        .load_en   (load_en),
        .load_data (rd_data),
        .frm_flag  (frm_flag),
        .frm_addr  (frm_addr),
        .frm_data  (frm_data),
        .dout      (sdata_out)
    );

    ser_cfg_regfile #(.DATA_W(DW), .ADDR_W(AW), .NUM_REGS(NR)) u_regs (
        .clk       (sclk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .addr      (frm_addr),
        .wr_data   (frm_data),
        .rd_data   (rd_data),
        .regs_flat (cfg_flat)
    );

    // R1: enable is low whenever reset is held
    always_comb begin
        if (!rst_n) begin
            a_r1_reset_oe_low: assert (!sdata_oe);
        end
    end

endmodule

// File: tb/ser_cfg_port_bench.sv
module ser_cfg_port_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NR = 7;

    logic        sclk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_n = 1'b1;
    logic        sdata_in = 1'b0;
    logic        sdata_out;
    logic        sdata_oe;
    logic [76:0] cfg_flat;

    int checks = 0;
    int errors = 0;
    logic [10:0] model [NR];

    always #(CLK_PERIOD/2) sclk = ~sclk;

    ser_cfg_port u_ser_cfg_port (
        .sclk(sclk), .rst_n(rst_n), .sel_n(sel_n), .sdata_in(sdata_in),
        .sdata_out(sdata_out), .sdata_oe(sdata_oe), .cfg_flat(cfg_flat)
    );

    function automatic logic [10:0] dflt(input int i);
        logic [10:0] t [NR] = '{11'h04F, 11'h003, 11'h006, 11'h013,
                                11'h5DC, 11'h5C1, 11'h047};
        return t[i];
    endfunction

    function automatic logic [10:0] read_expect(input int a);
        return (a < NR) ? model[a] : 11'h000;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic check_regs(input string tag);
        for (int i = 0; i < NR; i++) begin
            chk(cfg_flat[i*11 +: 11] == model[i], tag,
                32'(cfg_flat[i*11 +: 11]), 32'(model[i]));
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < NR; i++) model[i] = dflt(i);
    endtask

    // shift `pre` junk bits, then a frame, then one commit edge
    task automatic send_frame(input bit flag, input int a, input logic [10:0] d,
                              input int pre);
        logic [14:0] bits;
        bits = {d, 3'(a), flag};
        for (int i = 0; i < pre; i++) begin
            @(negedge sclk); sel_n = 1'b0; sdata_in = 1'($urandom);
        end
        for (int i = 0; i < 15; i++) begin
            @(negedge sclk); sel_n = 1'b0; sdata_in = bits[i];
        end
        @(negedge sclk); sel_n = 1'b1; sdata_in = 1'($urandom);
        @(posedge sclk);
    endtask

    task automatic do_write(input int a, input logic [10:0] d, input int pre);
        send_frame(1'b0, a, d, pre);
        if (a < NR) model[a] = d;
        @(negedge sclk);
        check_regs((a < NR) ? "R3 write" : "R5 high write");
    endtask

    task automatic do_read(input int a);
        logic [13:0] got;
        logic [13:0] exp;
        send_frame(1'b1, a, 11'($urandom), 0);
        @(negedge sclk);
        chk(sdata_oe == 1'b1, "R6 oe after read commit", 32'(sdata_oe), 1);
        for (int i = 0; i < 14; i++) begin
            if (i > 0) @(negedge sclk);
            got[i] = sdata_out;
            sel_n = 1'b0;
        end
        @(negedge sclk);
        sel_n = 1'b1;
        @(negedge sclk);
        exp = {read_expect(a), 3'(a)};
        chk(got == exp, (a < NR) ? "R6 read data" : "R5 high read zero",
            32'(got), 32'(exp));
        chk(sdata_oe == 1'b1, "R7 oe held", 32'(sdata_oe), 1);
        sel_n = 1'b0; sdata_in = 1'b0;
        #1;
        chk(sdata_oe == 1'b0, "R7 oe released", 32'(sdata_oe), 0);
        check_regs("R9 read no change");
    endtask

    initial begin
        repeat (150000) @(posedge sclk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1522));
        model_reset();
        repeat (2) @(negedge sclk);
        check_regs("R1 defaults in reset");
        chk(sdata_oe == 1'b0, "R1 oe in reset", 32'(sdata_oe), 0);
        rst_n = 1'b1;
        @(negedge sclk);
        check_regs("R1 defaults after reset");

        do_write(2, 11'h5A5, 0);
        do_read(2);
        do_read(4);
        do_write(7, 11'h7FF, 0);
        do_read(7);
        do_write(0, 11'h2AB, 5);
        do_write(6, 11'h000, 0);
        repeat (6) @(negedge sclk);
        check_regs("R4 idle edges");

        for (int n = 0; n < 80; n++) begin
            int a;
            a = int'($urandom % 8);
            if ($urandom % 2 == 0) do_write(a, 11'($urandom), int'($urandom % 3));
            else do_read(a);
        end
        do_write(1, 11'h155, 0);

        for (int i = 0; i < 8; i++) begin
            @(negedge sclk); sel_n = 1'b0; sdata_in = 1'b0;
        end
        @(negedge sclk);
        rst_n = 1'b0;
        model_reset();
        #1;
        check_regs("R8 reset mid-frame");
        chk(sdata_oe == 1'b0, "R8 oe after reset", 32'(sdata_oe), 0);
        @(negedge sclk); rst_n = 1'b1; sel_n = 1'b1;
        repeat (3) @(negedge sclk);
        check_regs("R8 no stale commit");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule